// File: doc/BRIEF.md
# HDLC Bit-Synchronous Frame Transmitter

This block turns byte frames into a serial bit-synchronous HDLC line stream, one line bit per clock. An upstream source offers address, control and information bytes on a valid/ready byte port and marks the final byte of each frame. The transmitter wraps each frame in flags, appends a 16-bit frame check sequence, and inserts a zero after every run of five ones inside the frame body.

Between frames the line carries an idle condition chosen by a select input. Three command strobes control the transmitter: reset, enable and abort. After reset the transmitter is disabled. Enable brings it to idle. Abort sends an all-ones byte that a receiver treats as a discarded frame. The transmitter also aborts on its own if the source runs dry in the middle of a frame. The transmit-ready output shows whether the transmitter is enabled.

Top module: `hdlc_tx_framer`

## Requirements
- R1: After `rst_n` low, or a one-cycle `cmd_reset` pulse, the transmitter is disabled. In this state `txd` is 1, `tx_ready` is 0 and `in_ready` stays 0 even when `in_valid` is high.
- R2: A `cmd_enable` pulse while disabled moves the transmitter to idle, and `tx_ready` becomes 1.
- R3: In idle with `idle_sel`=0, `txd` is a constant 1. With `idle_sel`=1, `txd` repeats the 8 bits of `idle_pat` with period 8, bit 0 first, and no zeros are inserted.
- R4: A frame starts at an idle byte boundary with exactly one flag, 8'h7E sent bit 0 first. The frame bytes follow in the order accepted, each sent bit 0 first. A byte is accepted in a cycle where `in_valid` and `in_ready` are both high, and `in_last`=1 marks the final byte.
- R5: After the final byte the transmitter sends a 16-bit FCS. It is the reflected CRC-CCITT (x^16+x^12+x^5+1), preset to 16'hFFFF and inverted, sent low-order bit first. For the bytes "123456789" the FCS is 16'h906E, which goes out as byte 8'h6E and then byte 8'h90.
- R6: One closing flag follows the FCS. If no byte is offered by the end of that flag, the line returns to the idle condition.
- R7: If the next frame's first byte is already offered when a closing flag ends, the closing flag is followed by exactly one separate opening flag, so two flags stand between the frames.
- R8: In the frame bytes and the FCS, a 0 is inserted after every five consecutive 1s. The run counter is cleared by flags and aborts. Flags, abort bits and idle bits are never stuffed.
- R9: A `cmd_abort` pulse in any enabled state sends eight consecutive 1s starting with the next line bit, then returns to idle. The interrupted frame is never closed.
- R10: If a non-final byte has been fully sent and no next byte is offered, the transmitter sends the eight-ones abort instead of a truncated frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one line bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_reset | input | 1 | Synchronous transmitter reset strobe |
| cmd_enable | input | 1 | Leave the disabled state |
| cmd_abort | input | 1 | Send the eight-ones abort |
| idle_sel | input | 1 | 0: idle ones, 1: repeat idle pattern |
| idle_pat | input | 8 | Idle pattern byte |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Offered byte ends the frame |
| in_ready | output | 1 | Byte taken this cycle |
| tx_ready | output | 1 | Transmitter enabled |
| txd | output | 1 | Serial line output |

## Verification
Frames are decoded from the line by a bench receiver that finds flags, removes inserted zeros and checks the FCS. Frames are drawn from a table. A nine-byte check string pins the FCS to a known constant. A frame of 8'hFF, 8'hFF, 8'h7E shows that zeros are inserted and that flag-like bytes survive. A two-byte address frame, an all-zero frame, and a frame whose ones runs cross byte boundaries show that run counting carries from one byte to the next. Directed runs cover the following:
- A back-to-back pair, where the flag count between the frames separates a shared flag from a close-then-open pair.
- An abort sent over an all-zero idle pattern, where the length of the ones run separates eight ones from a shorter or longer burst.
- A mid-frame abort, a source underrun and a mid-frame reset, where the receiver must report a discarded frame and never a complete one.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    localparam int BYTE_W = 8;
    localparam int FCS_W  = 16;
    localparam int CNT_W  = $clog2(FCS_W);
    localparam int RUN_W  = 3;

    localparam logic [BYTE_W-1:0] FLAG_BYTE = 8'h7E;

    typedef enum logic [2:0] {
        S_OFF,
        S_IDLE,
        S_OPEN,
        S_DATA,
        S_FCS,
        S_CLOSE,
        S_ABORT
    } tx_state_e;

    typedef struct packed {
        tx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [RUN_W-1:0]  ones;
        logic [BYTE_W-1:0] shreg;
        logic              last;
        logic              txd;
    } seq_regs_t;

endpackage

// File: rtl/hdlc_tx_fcs.sv
module hdlc_tx_fcs #(
    parameter int               W    = 16,
    parameter logic [W-1:0]     POLY = 16'h8408,
    parameter logic [W-1:0]     INIT = 16'hFFFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] crc_q
);

    logic [W-1:0] crc_d;
    logic         fb;

    always_comb begin
        fb    = crc_q[0] ^ din;
        crc_d = crc_q;
        if (init) begin
            crc_d = INIT;
        end else if (en) begin
            crc_d = (crc_q >> 1) ^ (fb ? POLY : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= INIT;
        else        crc_q <= crc_d;
    end

    // R5
    fcs_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (crc_q == INIT));

endmodule

// File: rtl/hdlc_tx_seq.sv
module hdlc_tx_seq
    import hdlc_tx_pkg::*;
#(
    parameter int STUFF_RUN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_reset,
    input  logic              cmd_enable,
    input  logic              cmd_abort,
    input  logic              idle_sel,
    input  logic [BYTE_W-1:0] idle_pat,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    input  logic [FCS_W-1:0]  crc_val,
    output logic              crc_init,
    output logic              crc_en,
    output logic              crc_bit,
    output logic              tx_ready,
    output logic              txd
);

    localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] FCS_END  = CNT_W'(FCS_W - 1);
    localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(STUFF_RUN);

    localparam seq_regs_t REGS_RST = '{
        state: S_OFF, cnt: '0, ones: '0, shreg: '0, last: 1'b0, txd: 1'b1
    };

    seq_regs_t q, d;
    logic      stuff_now;
    logic      byte_end;
    logic      cur_bit;
    logic      frame_busy;

    assign tx_ready = (q.state != S_OFF);
    assign txd      = q.txd;

    always_comb begin
        d          = q;
        in_ready   = 1'b0;
        crc_init   = 1'b0;
        crc_en     = 1'b0;
        crc_bit    = 1'b0;
        cur_bit    = 1'b0;
        byte_end   = (q.cnt[2:0] == BYTE_END[2:0]);
        stuff_now  = (q.state inside {S_DATA, S_FCS, S_CLOSE}) && (q.ones == RUN_MAX);
        frame_busy = (q.state inside {S_OPEN, S_DATA, S_FCS, S_CLOSE});

        unique case (q.state)
            S_OFF: begin
                d.txd = 1'b1;
                if (cmd_enable) begin
                    d.state = S_IDLE;
                    d.cnt   = '0;
                end
            end
            S_IDLE: begin
                d.txd  = idle_sel ? idle_pat[q.cnt[2:0]] : 1'b1;
                d.cnt  = {1'b0, q.cnt[2:0] + 3'd1};
                d.ones = '0;
                if (byte_end && in_valid) begin
                    d.state = S_OPEN;
                    d.cnt   = '0;
                end
            end
            S_OPEN: begin
                d.txd    = FLAG_BYTE[q.cnt[2:0]];
                d.ones   = '0;
                d.cnt    = q.cnt + CNT_W'(1);
                crc_init = 1'b1;
                if (byte_end) begin
                    d.cnt = '0;
                    if (in_valid) begin
                        in_ready = 1'b1;
                        d.shreg  = in_data;
                        d.last   = in_last;
                        d.state  = S_DATA;
                    end else begin
                        d.state = S_IDLE;
                    end
                end
            end
            S_DATA: begin
                if (stuff_now) begin
                    d.txd  = 1'b0;
                    d.ones = '0;
                end else begin
                    cur_bit = q.shreg[q.cnt[2:0]];
                    d.txd   = cur_bit;
                    crc_en  = 1'b1;
                    crc_bit = cur_bit;
                    d.ones  = cur_bit ? q.ones + RUN_W'(1) : '0;
                    d.cnt   = q.cnt + CNT_W'(1);
                    if (byte_end) begin
                        d.cnt = '0;
                        if (q.last) begin
                            d.state = S_FCS;
                        end else if (in_valid) begin
                            in_ready = 1'b1;
                            d.shreg  = in_data;
                            d.last   = in_last;
                        end else begin
                            d.state = S_ABORT;
                        end
                    end
                end
            end
            S_FCS: begin
                if (stuff_now) begin
                    d.txd  = 1'b0;
                    d.ones = '0;
                end else begin
                    cur_bit = ~crc_val[q.cnt];
                    d.txd   = cur_bit;
                    d.ones  = cur_bit ? q.ones + RUN_W'(1) : '0;
                    d.cnt   = q.cnt + CNT_W'(1);
                    if (q.cnt == FCS_END) begin
                        d.cnt   = '0;
                        d.state = S_CLOSE;
                    end
                end
            end
            S_CLOSE: begin
                if (stuff_now) begin
                    d.txd  = 1'b0;
                    d.ones = '0;
                end else begin
                    d.txd  = FLAG_BYTE[q.cnt[2:0]];
                    d.ones = '0;
                    d.cnt  = q.cnt + CNT_W'(1);
                    if (byte_end) begin
                        d.cnt   = '0;
                        d.state = in_valid ? S_OPEN : S_IDLE;
                    end
                end
            end
            S_ABORT: begin
                d.txd  = 1'b1;
                d.ones = '0;
                d.cnt  = q.cnt + CNT_W'(1);
                if (byte_end) begin
                    d.cnt   = '0;
                    d.state = S_IDLE;
                end
            end
            default: d = REGS_RST;
        endcase

        if (cmd_abort && (frame_busy || q.state == S_IDLE)) begin
            d.state  = S_ABORT;
            d.txd    = 1'b1;
            d.cnt    = CNT_W'(1);
            d.ones   = '0;
            in_ready = 1'b0;
            crc_en   = 1'b0;
        end

        if (cmd_reset) begin
            d        = REGS_RST;
            in_ready = 1'b0;
            crc_en   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= REGS_RST;
        else        q <= d;
    end

    // R1
    off_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> (txd && !tx_ready));

    // R2
    enable_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_OFF && cmd_enable && !cmd_reset) |=> tx_ready);

    // R4
    ready_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (in_valid && (q.state inside {S_OPEN, S_DATA})));

    // R8
    stuff_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state inside {S_DATA, S_FCS} && q.ones == RUN_MAX && !cmd_abort && !cmd_reset)
        |=> !txd);

    // R8
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.ones <= RUN_MAX);

    // R9
    abort_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_abort && !cmd_reset && frame_busy) |=> (q.state == S_ABORT && txd));

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
    import hdlc_tx_pkg::*;
#(
    parameter int          STUFF_RUN = 5,
    parameter logic [15:0] FCS_POLY  = 16'h8408,
    parameter logic [15:0] FCS_INIT  = 16'hFFFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_reset,
    input  logic       cmd_enable,
    input  logic       cmd_abort,
    input  logic       idle_sel,
    input  logic [7:0] idle_pat,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       in_ready,
    output logic       tx_ready,
    output logic       txd
);

    logic [FCS_W-1:0] crc_val;
    logic             crc_init;
    logic             crc_en;
    logic             crc_bit;

    hdlc_tx_seq #(.STUFF_RUN(STUFF_RUN)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_reset  (cmd_reset),
        .cmd_enable (cmd_enable),
        .cmd_abort  (cmd_abort),
        .idle_sel   (idle_sel),
        .idle_pat   (idle_pat),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_last    (in_last),
        .in_ready   (in_ready),
        .crc_val    (crc_val),
        .crc_init   (crc_init),
        .crc_en     (crc_en),
        .crc_bit    (crc_bit),
        .tx_ready   (tx_ready),
        .txd        (txd)
    );

    hdlc_tx_fcs #(.W(FCS_W), .POLY(FCS_POLY), .INIT(FCS_INIT)) fcs_i (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (crc_init),
        .en    (crc_en),
        .din   (crc_bit),
        .crc_q (crc_val)
    );

endmodule

// File: tb/hdlc_tx_framer_tb.sv
module hdlc_tx_framer_tb_top;

    // 50 MHz: 20 time units per period
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_reset = 1'b0, cmd_enable = 1'b0, cmd_abort = 1'b0;
    logic       idle_sel = 1'b0;
    logic [7:0] idle_pat = 8'h00;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       in_ready, tx_ready, txd;

    always #10 clk = ~clk;

    hdlc_tx_framer dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_reset(cmd_reset), .cmd_enable(cmd_enable),
        .cmd_abort(cmd_abort), .idle_sel(idle_sel), .idle_pat(idle_pat),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .tx_ready(tx_ready), .txd(txd)
    );

    // frame table: byte 0 in the low bits
    localparam int NV = 5;
    localparam logic [71:0] VDAT [0:NV-1] = '{
        72'h39_38_37_36_35_34_33_32_31,
        72'h7E_FF_FF,
        72'hAA_03_C2_C1,
        72'h00_00_00,
        72'h7F_3F_FC_1F_F8
    };
    localparam int VLEN [0:NV-1] = '{9, 3, 4, 3, 5};

    // ---------------- bench receiver ----------------
    int         rx_ones = 0, rx_nbits = 0, rx_frames = 0, rx_aborts = 0;
    int         rx_stuffed = 0, rx_empty = 0, last_empty = 0, last_len = 0;
    bit         rx_coll = 1'b0;
    logic       bitbuf [0:255];
    logic [7:0] last_bytes [0:15];

    always @(negedge clk) begin
        if (rst_n) begin
            if (txd) begin
                rx_ones = rx_ones + 1;
                if (rx_ones == 7 && rx_coll && rx_nbits > 6) rx_aborts = rx_aborts + 1;
                if (rx_ones >= 7) rx_coll = 1'b0;
                else if (rx_coll && rx_nbits < 256) begin
                    bitbuf[rx_nbits] = 1'b1;
                    rx_nbits = rx_nbits + 1;
                end
            end else begin
                if (rx_ones == 5) begin
                    if (rx_coll) rx_stuffed = rx_stuffed + 1;
                end else if (rx_ones == 6) begin
                    if (rx_coll) begin
                        int fl;
                        fl = rx_nbits - 7;
                        if (fl == 0) rx_empty = rx_empty + 1;
                        else if (fl >= 32 && fl % 8 == 0 && fl <= 128) begin
                            for (int k = 0; k < fl / 8; k++)
                                for (int j = 0; j < 8; j++)
                                    last_bytes[k][j] = bitbuf[8*k+j];
                            last_len   = fl / 8;
                            last_empty = rx_empty;
                            rx_empty   = 0;
                            rx_frames  = rx_frames + 1;
                        end
                    end else begin
                        rx_empty = 0;
                    end
                    rx_coll  = 1'b1;
                    rx_nbits = 0;
                end else if (rx_coll && rx_nbits < 256) begin
                    bitbuf[rx_nbits] = 1'b0;
                    rx_nbits = rx_nbits + 1;
                end
                rx_ones = 0;
            end
        end
    end

    // ---------------- checking ----------------
    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_fcs(input logic [71:0] dat, input int n);
        logic [15:0] c;
        c = 16'hFFFF;
        for (int i = 0; i < n; i++)
            for (int j = 0; j < 8; j++) begin
                logic fb;
                fb = c[0] ^ dat[8*i+j];
                c  = (c >> 1) ^ (fb ? 16'h8408 : 16'h0000);
            end
        return ~c;
    endfunction

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) cmd_reset = 1'b1;
        else if (which == 1) cmd_enable = 1'b1;
        else cmd_abort = 1'b1;
        @(negedge clk);
        cmd_reset = 1'b0; cmd_enable = 1'b0; cmd_abort = 1'b0;
    endtask

    // push n bytes; stop (and drop valid) after stop_at accepted bytes
    task automatic push_frame(input logic [71:0] dat, input int n, input int stop_at);
        for (int i = 0; i < n; i++) begin
            if (i == stop_at) begin
                @(negedge clk);
                in_valid = 1'b0;
                return;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = dat[8*i +: 8];
            in_last  = (i == n - 1);
            #1;
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
            @(posedge clk);
        end
    endtask

    task automatic drop_valid();
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic wait_frames(input int target);
        for (int i = 0; i < 600 && rx_frames < target; i++) @(negedge clk);
    endtask

    task automatic check_frame(input int v);
        int   n, bad;
        logic [15:0] f;
        n = VLEN[v];
        chk(last_len == n + 2, "R4 frame length", last_len, n + 2);
        bad = 0;
        for (int k = 0; k < n; k++) if (last_bytes[k] != VDAT[v][8*k +: 8]) bad++;
        chk(bad == 0, "R4 byte order", bad, 0);
        f = ref_fcs(VDAT[v], n);
        chk({last_bytes[n+1], last_bytes[n]} == f, "R5 fcs",
            int'({last_bytes[n+1], last_bytes[n]}), int'(f));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail + 1);
        $finish;
    end

    initial begin
        int   f0, a0, s0, run, maxrun;
        logic bits [0:15];
        bit   ok, rot_ok, m;

        repeat (3) @(negedge clk);
        chk(txd == 1'b1, "R1 reset txd", int'(txd), 1);
        chk(tx_ready == 1'b0, "R1 reset tx_ready", int'(tx_ready), 0);
        rst_n = 1'b1;

        // R1: disabled ignores offered bytes
        in_valid = 1'b1; in_data = 8'h55;
        ok = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (in_ready !== 1'b0 || txd !== 1'b1) ok = 1'b0;
        end
        chk(ok, "R1 disabled holds line and refuses bytes", int'(ok), 1);
        in_valid = 1'b0;

        // R2
        pulse(1);
        chk(tx_ready == 1'b1, "R2 enable", int'(tx_ready), 1);

        // R3 ones idle
        ok = 1'b1;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) ok = 1'b0;
        end
        chk(ok, "R3 idle ones", int'(ok), 1);

        // R3 pattern idle
        idle_pat = 8'h2D; idle_sel = 1'b1;
        repeat (10) @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            bits[i] = txd;
        end
        ok = 1'b1;
        for (int i = 0; i < 8; i++) if (bits[i] != bits[i+8]) ok = 1'b0;
        rot_ok = 1'b0;
        for (int r = 0; r < 8; r++) begin
            m = 1'b1;
            for (int i = 0; i < 8; i++) if (bits[i] != idle_pat[(i + r) % 8]) m = 1'b0;
            if (m) rot_ok = 1'b1;
        end
        chk(ok && rot_ok, "R3 idle pattern repeats", int'(ok && rot_ok), 1);

        // R9: abort over all-zero idle gives exactly eight ones, then idle
        idle_pat = 8'h00;
        repeat (12) @(negedge clk);
        pulse(2);
        maxrun = 0; run = 0;
        for (int i = 0; i < 24; i++) begin
            if (txd) run++; else run = 0;
            if (run > maxrun) maxrun = run;
            @(negedge clk);
        end
        chk(maxrun == 8, "R9 abort ones run", maxrun, 8);
        chk(txd == 1'b0 && tx_ready, "R9 back to idle", int'(txd), 0);

        // table of frames, idle ones between them
        idle_sel = 1'b0;
        repeat (10) @(negedge clk);
        for (int v = 0; v < NV; v++) begin
            f0 = rx_frames; s0 = rx_stuffed;
            push_frame(VDAT[v], VLEN[v], 99);
            drop_valid();
            wait_frames(f0 + 1);
            chk(rx_frames == f0 + 1, "R6 frame closed", rx_frames - f0, 1);
            check_frame(v);
            if (v == 0)
                chk(last_bytes[9] == 8'h6E && last_bytes[10] == 8'h90,
                    "R5 check string fcs", int'({last_bytes[10], last_bytes[9]}), 16'h906E);
            if (v == 1)
                chk(rx_stuffed - s0 >= 3, "R8 zero insertion count", rx_stuffed - s0, 3);
            repeat (12) @(negedge clk);
            chk(txd == 1'b1, "R6 idle after close", int'(txd), 1);
        end

        // R7 back-to-back frames
        f0 = rx_frames;
        push_frame(VDAT[2], VLEN[2], 99);
        push_frame(VDAT[4], VLEN[4], 99);
        drop_valid();
        wait_frames(f0 + 2);
        chk(rx_frames == f0 + 2, "R7 both frames", rx_frames - f0, 2);
        chk(last_empty == 1, "R7 close plus open flag", last_empty, 1);
        check_frame(4);

        // R9 mid-frame abort
        repeat (10) @(negedge clk);
        f0 = rx_frames; a0 = rx_aborts;
        push_frame(VDAT[0], VLEN[0], 3);
        pulse(2);
        repeat (60) @(negedge clk);
        chk(rx_aborts == a0 + 1, "R9 frame aborted", rx_aborts - a0, 1);
        chk(rx_frames == f0, "R9 no frame closed", rx_frames - f0, 0);

        // R10 underrun
        f0 = rx_frames; a0 = rx_aborts;
        push_frame(VDAT[4], VLEN[4], 2);
        repeat (60) @(negedge clk);
        chk(rx_aborts == a0 + 1, "R10 underrun abort", rx_aborts - a0, 1);
        chk(rx_frames == f0, "R10 no frame closed", rx_frames - f0, 0);

        // R1 reset during a frame
        push_frame(VDAT[0], VLEN[0], 2);
        repeat (3) @(negedge clk);
        pulse(0);
        chk(txd == 1'b1 && tx_ready == 1'b0, "R1 channel reset", int'(tx_ready), 0);
        pulse(1);
        f0 = rx_frames;
        repeat (10) @(negedge clk);
        push_frame(VDAT[3], VLEN[3], 99);
        drop_valid();
        wait_frames(f0 + 1);
        chk(rx_frames == f0 + 1, "R2 frame after re-enable", rx_frames - f0, 1);
        check_frame(3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule